// File: doc/BRIEF.md
# Replicated-Register Steering Target Resolver

A register that exists once per hardware unit (per cache bank, per memory slice, per sub-slice) shares one address with all its copies. A read must be steered to one copy, and a copy that is fused off or powered down returns nothing useful. This block takes a register offset and the availability masks derived from fuses. It returns a group and instance pair that is sure to land on a live copy.

Each steering class has its own small table of programmable address windows. The classes are L3 bank, memory slice, cache-node (LNCF), DSS and instance-zero. The offset is compared against every window in parallel. The highest-priority class that matches selects the rule used to derive the target from the fuse masks. If no class matches, a default pair supplied from outside is returned. The result is registered and accompanied by a single-cycle valid pulse. Performing the register access itself is left to the caller.

Top module: `steer_resolver`

## Requirements
- R1: Window entry e of class c occupies slot c*N_RANGE+e of the flattened low, high and enable vectors. Entry e of class c hits when its enable bit is 1 and low <= offset <= high; both bounds are inclusive. A disabled entry never hits, whatever its bounds.
- R2: Class codes are L3 bank = 0, memory slice = 1, LNCF = 2, DSS = 3, instance-zero = 4, and none = 5. When several classes hit, the lowest code wins, and `cls_o` reports it.
- R3: When no class hits, `cls_o` = 5, `grp_o`/`inst_o` equal the default inputs sampled with the request, and `err_o` = 0.
- R4: Fuse bit i of `bank_fuse_i` enables banks 2i and 2i+1. For the L3-bank class, `inst_o` is the lowest enabled bank index and `grp_o` = 0.
- R5: Memory slice s is live when `mem_en_i[s]` is 1 or any bit of `dss_en_i[s*DSS_PER_SLICE +: DSS_PER_SLICE]` is 1. For the memory-slice class, `grp_o` is the lowest live slice and `inst_o` = 0.
- R6: For the LNCF class, `grp_o` is twice the lowest live slice index and `inst_o` = 0.
- R7: For the DSS class, the lowest set bit d of `dss_en_i` gives `grp_o` = d / DSS_PER_SLICE and `inst_o` = d mod DSS_PER_SLICE.
- R8: For the instance-zero class, `grp_o` = 0, `inst_o` = 0 and `err_o` = 0 regardless of the masks.
- R9: When the winning class has an empty source mask (no enabled bank, no live slice, or no DSS), `err_o` = 1 and `grp_o` = `inst_o` = 0, with `cls_o` still naming that class.
- R10: `valid_o` is 1 exactly in the cycle after a cycle with `req_i` high. Outputs change only then, and all inputs are sampled on the request edge. After reset, `valid_o` = 0, `cls_o` = 5, and `grp_o`, `inst_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe; inputs sampled on this edge |
| ofs_i | input | OFS_W | Register offset to resolve |
| range_lo_i | input | NUM_CLS*N_RANGE*OFS_W | Window lower bounds, flattened |
| range_hi_i | input | NUM_CLS*N_RANGE*OFS_W | Window upper bounds, flattened |
| range_en_i | input | NUM_CLS*N_RANGE | Window enable bits |
| bank_fuse_i | input | BANK_FUSE_W | Bank-pair enable fuse field |
| mem_en_i | input | N_SLICE | Memory-L3 enable per slice |
| dss_en_i | input | N_SLICE*DSS_PER_SLICE | DSS enable mask |
| dflt_grp_i | input | GRP_W | Default group when no class hits |
| dflt_inst_i | input | INST_W | Default instance when no class hits |
| grp_o | output | GRP_W | Resolved group |
| inst_o | output | INST_W | Resolved instance |
| cls_o | output | 3 | Winning class code |
| err_o | output | 1 | Winning class had no live unit |
| valid_o | output | 1 | Result valid pulse |

## Verification
Priority resolution and the empty-mask error can act on the same request. This happens when an offset falls inside overlapping windows of two classes and the winning class has its mask cleared. The bench builds this directly: one offset lies in both an L3-bank window and a DSS window, and the bank fuse is zero. The check expects the L3-bank code with the error flag and a 0,0 pair, not a fall-through to the DSS target. Random tables with frequent overlaps and sparse or empty masks provoke the same collision repeatedly, and each result is compared against a reference model in the bench.

// File: rtl/steer_pkg.sv
package steer_pkg;

  typedef enum logic [2:0] {
    CLS_L3BANK = 3'd0,
    CLS_MSLICE = 3'd1,
    CLS_LNCF   = 3'd2,
    CLS_DSS    = 3'd3,
    CLS_INST0  = 3'd4,
    CLS_NONE   = 3'd5
  } steer_cls_e;

  localparam int unsigned NUM_CLS = 5;
  localparam int unsigned CLS_W   = 3;

endpackage

// File: rtl/steer_ffs.sv
// Lowest-set-bit finder.
module steer_ffs #(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign found_o = |vec_i;

endmodule

// File: rtl/steer_range_match.sv
// Inclusive window compare for one class table.
module steer_range_match #(
  parameter int unsigned OFS_W   = 24,
  parameter int unsigned N_RANGE = 2
) (
  input  logic [OFS_W-1:0]         ofs_i,
  input  logic [N_RANGE*OFS_W-1:0] lo_i,
  input  logic [N_RANGE*OFS_W-1:0] hi_i,
  input  logic [N_RANGE-1:0]       en_i,
  output logic                     hit_o
);

  logic [N_RANGE-1:0] entry_hit;

  for (genvar e = 0; e < N_RANGE; e++) begin : g_entry
    logic [OFS_W-1:0] lo_e;
    logic [OFS_W-1:0] hi_e;
    assign lo_e = lo_i[e*OFS_W +: OFS_W];
    assign hi_e = hi_i[e*OFS_W +: OFS_W];
    assign entry_hit[e] = en_i[e] && (ofs_i >= lo_e) && (ofs_i <= hi_e);
  end

  assign hit_o = |entry_hit;

endmodule

// File: rtl/steer_target_calc.sv
// Per-class target derivation from fuse masks.
module steer_target_calc
  import steer_pkg::*;
#(
  parameter int unsigned N_SLICE       = 4,
  parameter int unsigned DSS_PER_SLICE = 4,
  parameter int unsigned BANK_FUSE_W   = 3,
  parameter int unsigned GRP_W         = 4,
  parameter int unsigned INST_W        = 4
) (
  input  logic [BANK_FUSE_W-1:0]             bank_fuse_i,
  input  logic [N_SLICE-1:0]                 mem_en_i,
  input  logic [N_SLICE*DSS_PER_SLICE-1:0]   dss_en_i,
  output logic [NUM_CLS-1:0][GRP_W-1:0]      cls_grp_o,
  output logic [NUM_CLS-1:0][INST_W-1:0]     cls_inst_o,
  output logic [NUM_CLS-1:0]                 cls_empty_o
);

  localparam int unsigned BANK_W      = 2 * BANK_FUSE_W;
  localparam int unsigned N_DSS       = N_SLICE * DSS_PER_SLICE;
  localparam int unsigned BANK_IDX_W  = (BANK_W > 1) ? $clog2(BANK_W) : 1;
  localparam int unsigned SLICE_IDX_W = (N_SLICE > 1) ? $clog2(N_SLICE) : 1;
  localparam int unsigned DSS_IDX_W   = (N_DSS > 1) ? $clog2(N_DSS) : 1;

  logic [BANK_W-1:0]      bank_mask;
  logic [N_SLICE-1:0]     slice_live;
  logic                   bank_found, slice_found, dss_found;
  logic [BANK_IDX_W-1:0]  bank_idx;
  logic [SLICE_IDX_W-1:0] slice_idx;
  logic [DSS_IDX_W-1:0]   dss_idx;

  for (genvar i = 0; i < BANK_FUSE_W; i++) begin : g_bank
    assign bank_mask[2*i]   = bank_fuse_i[i];
    assign bank_mask[2*i+1] = bank_fuse_i[i];
  end

  for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
    assign slice_live[s] = mem_en_i[s] | (|dss_en_i[s*DSS_PER_SLICE +: DSS_PER_SLICE]);
  end

  steer_ffs #(.W(BANK_W), .IDX_W(BANK_IDX_W)) u_bank_ffs (
    .vec_i(bank_mask), .found_o(bank_found), .idx_o(bank_idx));

  steer_ffs #(.W(N_SLICE), .IDX_W(SLICE_IDX_W)) u_slice_ffs (
    .vec_i(slice_live), .found_o(slice_found), .idx_o(slice_idx));

  steer_ffs #(.W(N_DSS), .IDX_W(DSS_IDX_W)) u_dss_ffs (
    .vec_i(dss_en_i), .found_o(dss_found), .idx_o(dss_idx));

  always_comb begin
    cls_grp_o  = '0;
    cls_inst_o = '0;

    cls_inst_o[CLS_L3BANK] = INST_W'(bank_idx);
    cls_grp_o[CLS_MSLICE]  = GRP_W'(slice_idx);
    cls_grp_o[CLS_LNCF]    = GRP_W'({slice_idx, 1'b0});
    cls_grp_o[CLS_DSS]     = GRP_W'(int'(dss_idx) / int'(DSS_PER_SLICE));
    cls_inst_o[CLS_DSS]    = INST_W'(int'(dss_idx) % int'(DSS_PER_SLICE));

    cls_empty_o             = '0;
    cls_empty_o[CLS_L3BANK] = !bank_found;
    cls_empty_o[CLS_MSLICE] = !slice_found;
    cls_empty_o[CLS_LNCF]   = !slice_found;
    cls_empty_o[CLS_DSS]    = !dss_found;
    cls_empty_o[CLS_INST0]  = 1'b0;
  end

endmodule

// File: rtl/steer_resolver.sv
// Steering target resolver top: window match, priority pick, registered result.
module steer_resolver
  import steer_pkg::*;
#(
  parameter int unsigned OFS_W         = 24,
  parameter int unsigned N_RANGE       = 2,
  parameter int unsigned N_SLICE       = 4,
  parameter int unsigned DSS_PER_SLICE = 4,
  parameter int unsigned BANK_FUSE_W   = 3,
  parameter int unsigned GRP_W         = 4,
  parameter int unsigned INST_W        = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_i,
  input  logic [OFS_W-1:0]                   ofs_i,
  input  logic [NUM_CLS*N_RANGE*OFS_W-1:0]   range_lo_i,
  input  logic [NUM_CLS*N_RANGE*OFS_W-1:0]   range_hi_i,
  input  logic [NUM_CLS*N_RANGE-1:0]         range_en_i,
  input  logic [BANK_FUSE_W-1:0]             bank_fuse_i,
  input  logic [N_SLICE-1:0]                 mem_en_i,
  input  logic [N_SLICE*DSS_PER_SLICE-1:0]   dss_en_i,
  input  logic [GRP_W-1:0]                   dflt_grp_i,
  input  logic [INST_W-1:0]                  dflt_inst_i,
  output logic [GRP_W-1:0]                   grp_o,
  output logic [INST_W-1:0]                  inst_o,
  output logic [CLS_W-1:0]                   cls_o,
  output logic                               err_o,
  output logic                               valid_o
);

  localparam int unsigned TBL_W = N_RANGE * OFS_W;

  logic [NUM_CLS-1:0]              class_hit;
  logic [NUM_CLS-1:0][GRP_W-1:0]   cls_grp;
  logic [NUM_CLS-1:0][INST_W-1:0]  cls_inst;
  logic [NUM_CLS-1:0]              cls_empty;

  steer_cls_e       sel_cls;
  logic [GRP_W-1:0] grp_d;
  logic [INST_W-1:0] inst_d;
  logic             err_d;

  logic [GRP_W-1:0]  grp_q;
  logic [INST_W-1:0] inst_q;
  steer_cls_e        cls_q;
  logic              err_q;
  logic              valid_q;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    steer_range_match #(.OFS_W(OFS_W), .N_RANGE(N_RANGE)) u_match (
      .ofs_i (ofs_i),
      .lo_i  (range_lo_i[c*TBL_W +: TBL_W]),
      .hi_i  (range_hi_i[c*TBL_W +: TBL_W]),
      .en_i  (range_en_i[c*N_RANGE +: N_RANGE]),
      .hit_o (class_hit[c])
    );
  end

  steer_target_calc #(
    .N_SLICE(N_SLICE), .DSS_PER_SLICE(DSS_PER_SLICE),
    .BANK_FUSE_W(BANK_FUSE_W), .GRP_W(GRP_W), .INST_W(INST_W)
  ) u_calc (
    .bank_fuse_i (bank_fuse_i),
    .mem_en_i    (mem_en_i),
    .dss_en_i    (dss_en_i),
    .cls_grp_o   (cls_grp),
    .cls_inst_o  (cls_inst),
    .cls_empty_o (cls_empty)
  );

  // Next-state: priority pick, lowest class code wins.
  always_comb begin
    sel_cls = CLS_NONE;
    for (int c = NUM_CLS - 1; c >= 0; c--) begin
      if (class_hit[c]) sel_cls = steer_cls_e'(c);
    end

    if (sel_cls == CLS_NONE) begin
      grp_d  = dflt_grp_i;
      inst_d = dflt_inst_i;
      err_d  = 1'b0;
    end else if (cls_empty[sel_cls]) begin
      grp_d  = '0;
      inst_d = '0;
      err_d  = 1'b1;
    end else begin
      grp_d  = cls_grp[sel_cls];
      inst_d = cls_inst[sel_cls];
      err_d  = 1'b0;
    end
  end

  // Registers: result loads only on a request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q   <= '0;
      inst_q  <= '0;
      cls_q   <= CLS_NONE;
      err_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= req_i;
      if (req_i) begin
        grp_q  <= grp_d;
        inst_q <= inst_d;
        cls_q  <= sel_cls;
        err_q  <= err_d;
      end
    end
  end

  assign grp_o   = grp_q;
  assign inst_o  = inst_q;
  assign cls_o   = cls_q;
  assign err_o   = err_q;
  assign valid_o = valid_q;

  // Assertions
  assert_valid_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> valid_o);

  assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !valid_o);

  assert_hold_between_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(grp_o) && $stable(inst_o) && $stable(cls_o) && $stable(err_o)));

  assert_default_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && (class_hit == '0)) |=>
      (cls_o == CLS_NONE && !err_o && grp_o == $past(dflt_grp_i) && inst_o == $past(dflt_inst_i)));

  assert_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && class_hit[0]) |=> (cls_o == CLS_L3BANK));

  assert_inst0_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cls_o == CLS_INST0) |-> (grp_o == '0 && inst_o == '0 && !err_o));

  assert_err_zero_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && err_o) |-> (grp_o == '0 && inst_o == '0 && cls_o != CLS_NONE));

  assert_lncf_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cls_o == CLS_LNCF) |-> (grp_o[0] == 1'b0 && inst_o == '0));

  assert_mslice_inst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cls_o == CLS_MSLICE) |-> (inst_o == '0));

  assert_l3_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cls_o == CLS_L3BANK) |-> (grp_o == '0));

endmodule

// File: tb/steer_resolver_tb.sv
module steer_resolver_tb_top;

  localparam int OFS_W = 24;
  localparam int NR    = 2;
  localparam int NC    = 5;
  localparam int NS    = 4;
  localparam int DPS   = 4;
  localparam int NDSS  = NS * DPS;
  localparam int BFW   = 3;
  localparam int GW    = 4;
  localparam int IW    = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic req;
  logic [OFS_W-1:0] ofs;
  logic [NC*NR*OFS_W-1:0] lo_flat, hi_flat;
  logic [NC*NR-1:0] en_flat;
  logic [BFW-1:0] fuse;
  logic [NS-1:0] mem_en;
  logic [NDSS-1:0] dss_en;
  logic [GW-1:0] dgrp;
  logic [IW-1:0] dinst;
  logic [GW-1:0] grp;
  logic [IW-1:0] inst;
  logic [2:0] cls;
  logic err, valid;

  logic [OFS_W-1:0] tb_lo [NC][NR];
  logic [OFS_W-1:0] tb_hi [NC][NR];
  logic             tb_en [NC][NR];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  for (genvar c = 0; c < NC; c++) begin : g_c
    for (genvar e = 0; e < NR; e++) begin : g_e
      assign lo_flat[(c*NR+e)*OFS_W +: OFS_W] = tb_lo[c][e];
      assign hi_flat[(c*NR+e)*OFS_W +: OFS_W] = tb_hi[c][e];
      assign en_flat[c*NR+e] = tb_en[c][e];
    end
  end

  steer_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ofs_i(ofs),
    .range_lo_i(lo_flat), .range_hi_i(hi_flat), .range_en_i(en_flat),
    .bank_fuse_i(fuse), .mem_en_i(mem_en), .dss_en_i(dss_en),
    .dflt_grp_i(dgrp), .dflt_inst_i(dinst),
    .grp_o(grp), .inst_o(inst), .cls_o(cls), .err_o(err), .valid_o(valid)
  );

  // Reference model: {cls[2:0], err, grp[3:0], inst[3:0]}
  function automatic logic [11:0] model();
    int c_win = 5;
    int g = 0, n = 0;
    bit e_flag = 0;
    int first_bank = -1, first_slice = -1, first_dss = -1;
    for (int c = NC - 1; c >= 0; c--)
      for (int e = 0; e < NR; e++)
        if (tb_en[c][e] && ofs >= tb_lo[c][e] && ofs <= tb_hi[c][e]) c_win = c;
    for (int b = 2*BFW - 1; b >= 0; b--) if (fuse[b/2]) first_bank = b;
    for (int s = NS - 1; s >= 0; s--) begin
      bit live = mem_en[s];
      for (int k = 0; k < DPS; k++) if (dss_en[s*DPS+k]) live = 1;
      if (live) first_slice = s;
    end
    for (int d = NDSS - 1; d >= 0; d--) if (dss_en[d]) first_dss = d;
    case (c_win)
      0: if (first_bank < 0) e_flag = 1; else n = first_bank;
      1: if (first_slice < 0) e_flag = 1; else g = first_slice;
      2: if (first_slice < 0) e_flag = 1; else g = 2 * first_slice;
      3: if (first_dss < 0) e_flag = 1; else begin g = first_dss / DPS; n = first_dss % DPS; end
      4: begin g = 0; n = 0; end
      default: begin g = int'(dgrp); n = int'(dinst); end
    endcase
    return {3'(c_win), e_flag, 4'(g), 4'(n)};
  endfunction

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual {valid,cls,err,grp,inst}=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_tables();
    for (int c = 0; c < NC; c++)
      for (int e = 0; e < NR; e++) begin
        tb_lo[c][e] = '0; tb_hi[c][e] = '0; tb_en[c][e] = 1'b0;
      end
  endtask

  // Drive at negedge, strobe one cycle, sample at following negedge.
  task automatic resolve(input string tag, input logic [OFS_W-1:0] o);
    logic [11:0] exp;
    @(negedge clk);
    ofs = o;
    req = 1'b1;
    #1 exp = model();
    @(negedge clk);
    req = 1'b0;
    check(tag, {valid, cls, err, grp, inst}, {1'b1, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [12:0] held;
    int unsigned seed_set;
    seed_set = $urandom(32'd2024);
    clear_tables();
    rst_n = 1'b0; req = 1'b0; ofs = '0; fuse = '0; mem_en = '0; dss_en = '0;
    dgrp = 4'd9; dinst = 4'd6;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset", {valid, cls, err, grp, inst}, {1'b0, 3'd5, 1'b0, 4'd0, 4'd0});
    rst_n = 1'b1;
    @(negedge clk);

    // R3 no windows: default pair
    resolve("R3 default", 24'h123);
    check("R3 default literal", {valid, cls, err, grp, inst}, {1'b1, 3'd5, 1'b0, 4'd9, 4'd6});

    // R1 inclusive bounds on L3-bank window, R4 bank pairing
    tb_lo[0][1] = 24'h100; tb_hi[0][1] = 24'h1FF; tb_en[0][1] = 1'b1;
    fuse = 3'b100;
    resolve("R1 low bound", 24'h100);
    check("R4 fuse bit2 -> bank4", {valid, cls, err, grp, inst}, {1'b1, 3'd0, 1'b0, 4'd0, 4'd4});
    resolve("R1 high bound", 24'h1FF);
    resolve("R1 below low", 24'h0FF);
    resolve("R1 above high", 24'h200);
    fuse = 3'b110;
    resolve("R4 lowest bank", 24'h180);
    check("R4 literal", {valid, cls, err, grp, inst}, {1'b1, 3'd0, 1'b0, 4'd0, 4'd2});

    // R1 disabled entry never hits
    tb_lo[1][0] = 24'h000; tb_hi[1][0] = 24'hFFFFFF; tb_en[1][0] = 1'b0;
    resolve("R1 disabled entry", 24'h800);

    // R5 memory slice live via DSS only
    tb_lo[1][0] = 24'h300; tb_hi[1][0] = 24'h30F; tb_en[1][0] = 1'b1;
    mem_en = 4'b0000; dss_en = 16'h0200;
    resolve("R5 live via dss", 24'h305);
    check("R5 literal", {valid, cls, err, grp, inst}, {1'b1, 3'd1, 1'b0, 4'd2, 4'd0});
    mem_en = 4'b1000; dss_en = 16'h0000;
    resolve("R5 live via mem", 24'h30F);

    // R6 LNCF doubled slice
    tb_lo[2][1] = 24'h400; tb_hi[2][1] = 24'h40F; tb_en[2][1] = 1'b1;
    mem_en = 4'b0010;
    resolve("R6 lncf", 24'h400);
    check("R6 literal", {valid, cls, err, grp, inst}, {1'b1, 3'd2, 1'b0, 4'd2, 4'd0});

    // R7 DSS split
    tb_lo[3][0] = 24'h500; tb_hi[3][0] = 24'h50F; tb_en[3][0] = 1'b1;
    dss_en = 16'h0040;
    resolve("R7 dss", 24'h50A);
    check("R7 literal", {valid, cls, err, grp, inst}, {1'b1, 3'd3, 1'b0, 4'd1, 4'd2});

    // R8 instance-zero with all masks empty
    tb_lo[4][0] = 24'h600; tb_hi[4][0] = 24'h600; tb_en[4][0] = 1'b1;
    fuse = '0; mem_en = '0; dss_en = '0;
    resolve("R8 inst0", 24'h600);
    check("R8 literal", {valid, cls, err, grp, inst}, {1'b1, 3'd4, 1'b0, 4'd0, 4'd0});

    // R2 + R9 overlap: L3 wins even though its mask is empty
    tb_lo[0][0] = 24'h700; tb_hi[0][0] = 24'h7FF; tb_en[0][0] = 1'b1;
    tb_lo[3][1] = 24'h780; tb_hi[3][1] = 24'h880; tb_en[3][1] = 1'b1;
    dss_en = 16'h0100;
    resolve("R2 R9 overlap", 24'h7C0);
    check("R9 literal", {valid, cls, err, grp, inst}, {1'b1, 3'd0, 1'b1, 4'd0, 4'd0});
    resolve("R2 dss beyond l3", 24'h800);

    // R10 hold without request and valid drop
    held = {valid, cls, err, grp, inst};
    @(negedge clk);
    ofs = 24'h123; fuse = 3'b111; dgrp = 4'd1;
    @(negedge clk);
    check("R10 hold", {valid, cls, err, grp, inst}, {1'b0, held[11:0]});

    // Random mix
    for (int t = 0; t < 400; t++) begin
      for (int c = 0; c < NC; c++)
        for (int e = 0; e < NR; e++) begin
          tb_lo[c][e] = 24'($urandom_range(0, 32'h3F0));
          tb_hi[c][e] = tb_lo[c][e] + 24'($urandom_range(0, 32'h80));
          tb_en[c][e] = ($urandom_range(0, 9) < 7);
        end
      fuse   = ($urandom_range(0, 4) == 0) ? '0 : 3'($urandom);
      mem_en = ($urandom_range(0, 2) == 0) ? '0 : 4'($urandom);
      dss_en = ($urandom_range(0, 3) == 0) ? '0 : 16'($urandom & $urandom & $urandom);
      dgrp   = 4'($urandom);
      dinst  = 4'($urandom);
      resolve("R2 random", 24'($urandom_range(0, 32'h480)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule